// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block takes eight interrupt request inputs and keeps a request register for them. Each line is either level sensitive or edge sensitive, chosen by a per-line trigger-mode input. Requests that are not masked are compared against the lines already in service. The block raises a registered interrupt output when a pending request outranks everything in service, and it reports which line won.

Priority is relative to a three-bit offset. Relative position p stands for line (p + offset) mod 8, and the lowest position has the highest priority, so changing the offset rotates the ranking. Two mode bits change how the in-service ranking is formed. Special mask mode drops masked lines from the in-service set. Special nested mode, on a unit flagged as master, ignores the in-service bit of the cascade line.

The surrounding controller owns register programming and acknowledge sequencing. It drives the mask, in-service, offset and mode inputs, and it pulses a clear strobe to retire an edge-captured request once that request has been taken.

Top module: `irq_resolver`

## Requirements
- R1: While reset is active and after it is released, the request register and the previous-level record are all zero, `irq_out` is 0 and `win_line` is 0.
- R2: A request competes only when its mask bit is 0. A line whose `mask` bit is 1 never wins, and an unmasked request still wins while other lines are masked.
- R3: The pending requests are searched by relative position p = 0..7, where position p is line (p + `prio_offset`) mod 8. The smallest position holding a pending request wins.
- R4: The current priority is the same rotated search applied to the in-service set, or 8 when that set is empty. `irq_out` is raised only when the best pending position is strictly below the current priority. An equal position does not fire, and no pending request never fires.
- R5: When `special_mask` is 1, in-service bits whose mask bit is 1 are removed before the current priority is found.
- R6: When `special_nested` and `is_master` are both 1, in-service bit 2 (the cascade line) is ignored in the current priority. If either flag is 0, bit 2 counts normally.
- R7: For a line whose `trig_level` bit is 1 (level), the request bit equals the input level sampled at the previous clock edge. A `req_clr` strobe has no lasting effect on it.
- R8: For a line whose `trig_level` bit is 0 (edge), the request bit is set only when the input goes from 0 to 1. A falling input does not clear it. A `req_clr` bit of 1 clears it, unless a rising edge arrives in the same cycle, in which case the request is set. An input held high after a clear does not set the request again.
- R9: A change of `irq_req` shows at `irq_out` after the second rising clock edge. A change of `mask`, `in_service`, `prio_offset` or the mode bits shows after the first edge.
- R10: `win_line` holds the winning line index, which is (winning position + `prio_offset`) mod 8, while `irq_out` is 1. It is 0 while `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 8 | Raw interrupt request lines |
| trig_level | input | 8 | Per-line trigger mode: 1 = level, 0 = edge |
| req_clr | input | 8 | Per-line strobe that clears an edge-captured request |
| mask | input | 8 | Per-line mask: 1 = masked |
| in_service | input | 8 | Lines currently being serviced |
| prio_offset | input | 3 | Rotation offset for the priority search |
| special_mask | input | 1 | Removes masked lines from the in-service set |
| special_nested | input | 1 | Ignores the cascade line in service (master only) |
| is_master | input | 1 | Marks this unit as the master of a cascade |
| irq_out | output | 1 | Registered interrupt request output |
| win_line | output | 3 | Registered index of the winning line |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that the mask, in-service, offset and mode inputs are supplied by synchronous logic, so they settle between edges. The bench keeps to this. It changes every input one time unit after a rising edge and holds it for whole cycles. Clear strobes last exactly one cycle. The mode bits are only changed while the request pattern is steady, so that each observed output can be traced to one cause.

// File: rtl/irq_resolver_pkg.sv
// Package: shared constants and types of the interrupt resolver.
// Assumes: the line count is a power of two, so rotation is a plain
// truncated add.
package irq_resolver_pkg;

    // Default number of request lines handled by one resolver.
    localparam int DEF_LINES = 8;

    // Default line index of the cascade input on a master unit.
    localparam int DEF_CASCADE = 2;

    // Mode flags that shape how the in-service priority is formed.
    typedef struct packed {
        logic special_mask;
        logic special_nested;
        logic is_master;
    } res_mode_t;

endpackage

// File: rtl/irq_req_capture.sv
// Module: per-line request capture. A level line copies its input; an
// edge line is set on a 0->1 transition and held until a clear strobe.
// Assumes: the inputs are synchronous to clk. The previous-level record
// is updated on every line, whatever its mode, so that a mode switch
// never sees a stale history.
module irq_req_capture #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] raw_in,
    input  logic [N_LINES-1:0] is_level,
    input  logic [N_LINES-1:0] clr_in,
    output logic [N_LINES-1:0] req_q
);

    logic [N_LINES-1:0] last_lvl_q;

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        // Purpose: record the input level for edge detection on this line.
        always_ff @(posedge clk) begin
            if (!rst_n) last_lvl_q[gi] <= 1'b0;
            else        last_lvl_q[gi] <= raw_in[gi];
        end

        // Purpose: update this line's request bit by its trigger mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[gi] <= 1'b0;
            end else if (is_level[gi]) begin
                req_q[gi] <= raw_in[gi];
            end else if (raw_in[gi] && !last_lvl_q[gi]) begin
                req_q[gi] <= 1'b1;
            end else if (clr_in[gi]) begin
                req_q[gi] <= 1'b0;
            end
        end

        // R7
        level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(is_level[gi])) |-> (req_q[gi] == $past(raw_in[gi])));

        // R8
        edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(is_level[gi]) && $rose(req_q[gi])) |-> $past(raw_in[gi]));
    end

endmodule

// File: rtl/irq_prio_scan.sv
// Module: rotated priority search. It returns the smallest relative
// position whose line bit is set, where position p is line
// (p + offset) mod N. It returns N when no bit is set.
// Assumes: N_LINES is a power of two.
module irq_prio_scan #(
    parameter int N_LINES = 8,
    localparam int IDX_W = $clog2(N_LINES),
    localparam int POS_W = IDX_W + 1
) (
    input  logic [N_LINES-1:0] vec,
    input  logic [IDX_W-1:0]   offset,
    output logic [POS_W-1:0]   pos
);

    // Purpose: scan from the lowest priority upward so that the last hit,
    // which is the smallest position, wins.
    always_comb begin
        pos = POS_W'(N_LINES);
        for (int p = N_LINES - 1; p >= 0; p--) begin
            if (vec[IDX_W'(p) + offset]) pos = POS_W'(p);
        end
    end

endmodule

// File: rtl/irq_resolver.sv
// Module: top of the rotating priority interrupt resolver. It captures
// the requests and removes the masked ones. It forms the in-service
// priority under the special modes, compares the two and registers the
// interrupt output and the winning line.
// Assumes: the mask, in-service, offset and mode inputs are driven
// synchronously by the owning controller.
module irq_resolver
    import irq_resolver_pkg::*;
#(
    parameter int N_LINES = DEF_LINES,
    parameter int CASCADE_LINE = DEF_CASCADE,
    localparam int IDX_W = $clog2(N_LINES),
    localparam int POS_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_req,
    input  logic [N_LINES-1:0] trig_level,
    input  logic [N_LINES-1:0] req_clr,
    input  logic [N_LINES-1:0] mask,
    input  logic [N_LINES-1:0] in_service,
    input  logic [IDX_W-1:0]   prio_offset,
    input  logic               special_mask,
    input  logic               special_nested,
    input  logic               is_master,
    output logic               irq_out,
    output logic [IDX_W-1:0]   win_line
);

    res_mode_t          mode;
    logic [N_LINES-1:0] req_q;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] isr_eff;
    logic [POS_W-1:0]   best_pos;
    logic [POS_W-1:0]   cur_pos;
    logic               fire;
    logic [IDX_W-1:0]   win_next;
    logic               irq_q;
    logic [IDX_W-1:0]   win_q;

    assign mode = '{special_mask: special_mask,
                    special_nested: special_nested,
                    is_master: is_master};

    irq_req_capture #(.N_LINES(N_LINES)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (irq_req),
        .is_level (trig_level),
        .clr_in   (req_clr),
        .req_q    (req_q)
    );

    // Purpose: keep only the unmasked requests as candidates.
    always_comb pend = req_q & ~mask;

    // Purpose: form the in-service set that sets the current priority.
    always_comb begin
        isr_eff = in_service;
        if (mode.special_mask) isr_eff = isr_eff & ~mask;
        if (mode.special_nested && mode.is_master) isr_eff[CASCADE_LINE] = 1'b0;
    end

    irq_prio_scan #(.N_LINES(N_LINES)) u_scan_pend (
        .vec    (pend),
        .offset (prio_offset),
        .pos    (best_pos)
    );

    irq_prio_scan #(.N_LINES(N_LINES)) u_scan_isr (
        .vec    (isr_eff),
        .offset (prio_offset),
        .pos    (cur_pos)
    );

    // Purpose: decide whether to interrupt, and map the position to a line.
    always_comb begin
        fire     = best_pos < cur_pos;
        win_next = fire ? (best_pos[IDX_W-1:0] + prio_offset) : '0;
    end

    // Purpose: register the interrupt output and the winning line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            win_q <= '0;
        end else begin
            irq_q <= fire;
            win_q <= win_next;
        end
    end

    assign irq_out  = irq_q;
    assign win_line = win_q;

    logic [N_LINES-1:0] win_oh;
    assign win_oh = irq_q ? (N_LINES'(1) << win_q) : '0;

    // R2
    win_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (($past(req_q & ~mask) & win_oh) != '0));

    // R10
    idle_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_q |-> (win_q == '0));

    // R4
    no_req_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(pend) == '0)) |-> !irq_q);

    // R4
    full_isr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(isr_eff) == '1)) |-> !irq_q);

endmodule

// File: tb/irq_resolver_tb.sv
module irq_resolver_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic [7:0] trig_level = '0;
    logic [7:0] req_clr = '0;
    logic [7:0] mask = '0;
    logic [7:0] in_service = '0;
    logic [2:0] prio_offset = '0;
    logic       special_mask = 1'b0;
    logic       special_nested = 1'b0;
    logic       is_master = 1'b0;
    logic       irq_out;
    logic [2:0] win_line;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .trig_level(trig_level),
        .req_clr(req_clr), .mask(mask), .in_service(in_service),
        .prio_offset(prio_offset), .special_mask(special_mask),
        .special_nested(special_nested), .is_master(is_master),
        .irq_out(irq_out), .win_line(win_line)
    );

    task automatic check(input string tag, input logic e_irq, input logic [2:0] e_win);
        total++;
        if (irq_out !== e_irq || win_line !== e_win) begin
            bad++;
            $display("FAIL %s: actual irq=%b line=%0d expected irq=%b line=%0d",
                     tag, irq_out, win_line, e_irq, e_win);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_clr(input logic [7:0] bits);
        req_clr = bits;
        tick(1);
        req_clr = '0;
    endtask

    task automatic t_reset();
        irq_req = 8'hFF;
        tick(3);
        check("R1 in reset", 1'b0, 3'd0);
        irq_req = '0;
        tick(2);
        rst_n = 1'b1;
        tick(3);
        check("R1 after reset", 1'b0, 3'd0);
    endtask

    task automatic t_edge();
        irq_req[3] = 1'b1;
        tick(1);
        check("R9 edge not yet visible", 1'b0, 3'd0);
        tick(1);
        check("R9 edge visible after two edges", 1'b1, 3'd3);
        irq_req[3] = 1'b0;
        tick(3);
        check("R8 falling input keeps request", 1'b1, 3'd3);
        pulse_clr(8'h08);
        tick(2);
        check("R8 clear retires request", 1'b0, 3'd0);
        irq_req[3] = 1'b1;
        pulse_clr(8'h08);
        tick(2);
        check("R8 rise beats clear", 1'b1, 3'd3);
        pulse_clr(8'h08);
        tick(3);
        check("R8 held high no retrigger", 1'b0, 3'd0);
        irq_req[3] = 1'b0;
        tick(2);
        irq_req[3] = 1'b1;
        tick(3);
        check("R8 new rising edge", 1'b1, 3'd3);
        irq_req[3] = 1'b0;
        pulse_clr(8'h08);
        tick(3);
    endtask

    task automatic t_level();
        trig_level = 8'h60;
        irq_req[5] = 1'b1;
        tick(3);
        check("R7 level high requests", 1'b1, 3'd5);
        pulse_clr(8'h20);
        tick(2);
        check("R7 clear ignored on level", 1'b1, 3'd5);
        irq_req[5] = 1'b0;
        tick(3);
        check("R7 level low drops", 1'b0, 3'd0);
    endtask

    task automatic t_mask();
        irq_req[5] = 1'b1;
        mask = 8'h20;
        tick(3);
        check("R2 masked line silent", 1'b0, 3'd0);
        irq_req[6] = 1'b1;
        tick(3);
        check("R2 unmasked line wins", 1'b1, 3'd6);
        irq_req[6] = 1'b0;
        tick(3);
        check("R2 masked again silent", 1'b0, 3'd0);
        mask = '0;
        tick(1);
        check("R9 mask change after one edge", 1'b1, 3'd5);
        irq_req[5] = 1'b0;
        tick(3);
    endtask

    task automatic t_rotate();
        trig_level = 8'h42;
        irq_req = 8'h42;
        tick(3);
        check("R3 offset 0 picks line 1", 1'b1, 3'd1);
        prio_offset = 3'd2;
        tick(1);
        check("R3 offset 2 picks line 6", 1'b1, 3'd6);
        prio_offset = 3'd7;
        tick(2);
        check("R3 offset 7 picks line 1", 1'b1, 3'd1);
        prio_offset = 3'd6;
        tick(2);
        check("R10 offset 6 picks line 6", 1'b1, 3'd6);
        irq_req = '0;
        prio_offset = '0;
        tick(3);
        check("R4 no request no irq", 1'b0, 3'd0);
    endtask

    task automatic t_in_service();
        trig_level = 8'hFF;
        in_service = 8'h02;
        irq_req = 8'h10;
        tick(3);
        check("R4 lower priority blocked", 1'b0, 3'd0);
        irq_req = 8'h11;
        tick(3);
        check("R4 higher priority fires", 1'b1, 3'd0);
        irq_req = 8'h02;
        tick(3);
        check("R4 equal priority blocked", 1'b0, 3'd0);
        irq_req = 8'h10;
        mask = 8'h02;
        tick(3);
        check("R5 mode off masked isr blocks", 1'b0, 3'd0);
        special_mask = 1'b1;
        tick(2);
        check("R5 masked isr ignored", 1'b1, 3'd4);
        special_mask = 1'b0;
        mask = '0;
        in_service = 8'h04;
        irq_req = 8'h04;
        tick(3);
        check("R6 cascade in service blocks", 1'b0, 3'd0);
        special_nested = 1'b1;
        tick(2);
        check("R6 nested without master blocks", 1'b0, 3'd0);
        is_master = 1'b1;
        tick(2);
        check("R6 nested master ignores cascade", 1'b1, 3'd2);
        special_nested = 1'b0;
        tick(2);
        check("R6 master without nested blocks", 1'b0, 3'd0);
        irq_req = '0;
        in_service = '0;
        is_master = 1'b0;
        tick(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_edge();
        t_level();
        t_mask();
        t_rotate();
        t_in_service();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

endmodule